// File: doc/BRIEF.md
# Receive Gain Regulator with Signal-Strength Readout

This block keeps the gain-reduction code for a multi-channel low-frequency receive front end. A code of zero means the amplifiers run at their highest sensitivity; each step up trades sensitivity for headroom. Once per carrier period the block learns from the analog side whether the demodulated amplitude sits above a comparator reference. It nudges the code so the amplitude settles on that reference. The same code, read as an 8-bit number, is the received-signal-strength value handed to the host.

Regulation follows the strongest antenna. A channel counts as strong only if it is enabled and its own comparator reports "above". The code moves quickly while the carrier preamble is being acquired and slowly once it is tracking. When tracking, it backs off gain faster than it restores it, which limits distortion of the envelope. Carrier gaps and a host freeze request both hold the code. A host clear command or a change of channel selection returns it to full sensitivity and restarts acquisition.

The controller has three phases. `PH_STANDBY` holds the code at zero. It moves to `PH_ACQUIRE` once the preamble flag is high and no clear is pending. `PH_ACQUIRE` moves to `PH_TRACK` after the configured number of adjusting periods. From `PH_ACQUIRE` or `PH_TRACK`, a dropped preamble flag, a clear pulse or a channel-change pulse returns the block to `PH_STANDBY`.

Top module: `agc_rssi_core`

## Requirements
- R1: While reset is active, `rssi` is 0. A clock edge that samples `preamble_ok` low leaves `rssi` at 0 after that edge, and the controller is back in standby.
- R2: A clock edge in standby that samples `preamble_ok` high (with no clear or channel-change pulse) starts acquisition. During acquisition, each adjusting period moves `rssi` by exactly one: +1 when the strongest channel is above reference, −1 otherwise. An adjusting period is a cycle with `period_tick`=1, `gap`=0 and `freeze`=0.
- R3: Acquisition lasts 192 adjusting periods. After that, `rssi` rises by one after every 2nd consecutive "above" adjusting period, and falls by one after every 8th consecutive "below" adjusting period.
- R4: In tracking, a change of direction between adjusting periods restarts the consecutive-period count, with the new period counted as the first.
- R5: A cycle with `gap`=1 neither changes `rssi` nor advances any period count.
- R6: A cycle with `freeze`=1 neither changes `rssi` nor advances any period count.
- R7: A pulse on `soft_clr` or `chan_chg` sets `rssi` to 0 after that edge. Acquisition then restarts from the first period.
- R8: The strongest channel is above reference when bit i of `above_ref` and bit i of `chan_en` are both 1 for some i. Bits of disabled channels have no effect.
- R9: `rssi` saturates at 0 and at 255 and never wraps.
- R10: A cycle with `period_tick`=0 does not change `rssi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse per carrier period |
| above_ref | input | N_CH (3) | Per-channel amplitude-above-reference flags |
| chan_en | input | N_CH (3) | Per-channel enable mask |
| gap | input | 1 | Carrier absent (gap) flag |
| preamble_ok | input | 1 | Valid preamble seen; low means standby |
| freeze | input | 1 | Host request to hold the gain code |
| soft_clr | input | 1 | Host clear-command pulse |
| chan_chg | input | 1 | Channel-selection-changed pulse |
| rssi | output | CNT_W (8) | Gain-reduction code and signal-strength reading |

## Verification
Every result is due one clock after the edge that samples its stimulus. A tick, clear or preamble change seen at edge k shows on `rssi` from edge k onward, with no internal pipeline. Inputs are driven at the falling edge. At each falling edge the bench first compares `rssi` with its reference model, then applies new inputs and advances the model by one period. Each comparison therefore judges exactly the edge that sat between the two falling edges. The 192-period boundary, the 2/8 divider ratios and saturation are reached through long runs of identical periods. A pseudo-random phase then mixes gaps, freezes, masks and clears.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [1:0] {
        PH_STANDBY = 2'd0,
        PH_ACQUIRE = 2'd1,
        PH_TRACK   = 2'd2
    } agc_phase_e;

endpackage

// File: rtl/agc_strongest.sv
module agc_strongest #(
    parameter int N_CH = 3
) (
    input  logic [N_CH-1:0] above_ref,
    input  logic [N_CH-1:0] chan_en,
    output logic            hot
);

    logic [N_CH-1:0] qual;

    // one qualified comparator bit per channel
    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        assign qual[g] = above_ref[g] & chan_en[g];
    end

    assign hot = |qual;

endmodule

// File: rtl/agc_phase_fsm.sv
module agc_phase_fsm
    import agc_pkg::*;
#(
    parameter int ACQ_PERIODS = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preamble_ok,
    input  logic restart,
    input  logic adj,
    output logic active,
    output logic fast
);

    localparam int PW = (ACQ_PERIODS > 1) ? $clog2(ACQ_PERIODS) : 1;
    localparam logic [PW-1:0] LAST = PW'(ACQ_PERIODS - 1);

    agc_phase_e    state_q, state_d;
    logic [PW-1:0] pcnt_q, pcnt_d;
    logic          abort;

    assign abort = restart | ~preamble_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_STANDBY;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    // transitions and acquisition period count
    always_comb begin
        state_d = state_q;
        pcnt_d  = '0;
        unique case (state_q)
            PH_STANDBY: begin
                if (!restart && preamble_ok) state_d = PH_ACQUIRE;
            end
            PH_ACQUIRE: begin
                if (abort) begin
                    state_d = PH_STANDBY;
                end else if (adj && pcnt_q == LAST) begin
                    state_d = PH_TRACK;
                end else if (adj) begin
                    pcnt_d = pcnt_q + 1'b1;
                end else begin
                    pcnt_d = pcnt_q;
                end
            end
            PH_TRACK: begin
                if (abort) state_d = PH_STANDBY;
            end
            default: state_d = PH_STANDBY;
        endcase
    end

    // outputs
    always_comb begin
        active = 1'b0;
        fast   = 1'b0;
        unique case (state_q)
            PH_STANDBY: begin
                active = 1'b0;
                fast   = 1'b0;
            end
            PH_ACQUIRE: begin
                active = 1'b1;
                fast   = 1'b1;
            end
            PH_TRACK: begin
                active = 1'b1;
                fast   = 1'b0;
            end
            default: begin
                active = 1'b0;
                fast   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
    parameter int CNT_W  = 8,
    parameter int DN_DIV = 2,
    parameter int UP_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adj,
    input  logic             fast,
    input  logic             hot,
    output logic [CNT_W-1:0] level
);

    localparam int DMAX = (DN_DIV > UP_DIV) ? DN_DIV : UP_DIV;
    localparam int DW   = $clog2(DMAX + 1);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [DW-1:0]    DN_L = DW'(DN_DIV);
    localparam logic [DW-1:0]    UP_L = DW'(UP_DIV);

    logic [CNT_W-1:0] level_q, level_d;
    logic [DW-1:0]    div_q, div_d, run_len;
    logic             dir_q, dir_d;
    logic             fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            div_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            level_q <= level_d;
            div_q   <= div_d;
            dir_q   <= dir_d;
        end
    end

    always_comb begin
        run_len = (hot == dir_q) ? div_q + 1'b1 : DW'(1);
        fire    = fast | (hot ? (run_len == DN_L) : (run_len == UP_L));
        level_d = level_q;
        div_d   = div_q;
        dir_d   = dir_q;
        if (clear) begin
            level_d = '0;
            div_d   = '0;
            dir_d   = 1'b0;
        end else if (adj) begin
            dir_d = hot;
            div_d = fire ? '0 : run_len;
            if (fire) begin
                if (hot && level_q != TOP)       level_d = level_q + 1'b1;
                else if (!hot && level_q != '0)  level_d = level_q - 1'b1;
            end
        end
    end

    assign level = level_q;

endmodule

// File: rtl/agc_rssi_core.sv
module agc_rssi_core #(
    parameter int N_CH        = 3,
    parameter int CNT_W       = 8,
    parameter int ACQ_PERIODS = 192,
    parameter int DN_DIV      = 2,
    parameter int UP_DIV      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_tick,
    input  logic [N_CH-1:0]  above_ref,
    input  logic [N_CH-1:0]  chan_en,
    input  logic             gap,
    input  logic             preamble_ok,
    input  logic             freeze,
    input  logic             soft_clr,
    input  logic             chan_chg,
    output logic [CNT_W-1:0] rssi
);

    logic hot, active, fast, restart, abort, adj;

    assign restart = soft_clr | chan_chg;
    assign abort   = restart | ~preamble_ok;
    assign adj     = period_tick & ~gap & ~freeze & ~abort & active;

    agc_strongest #(.N_CH(N_CH)) u_strong (
        .above_ref (above_ref),
        .chan_en   (chan_en),
        .hot       (hot)
    );

    agc_phase_fsm #(.ACQ_PERIODS(ACQ_PERIODS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .preamble_ok (preamble_ok),
        .restart     (restart),
        .adj         (adj),
        .active      (active),
        .fast        (fast)
    );

    agc_gain_step #(.CNT_W(CNT_W), .DN_DIV(DN_DIV), .UP_DIV(UP_DIV)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (abort | ~active),
        .adj   (adj),
        .fast  (fast),
        .hot   (hot),
        .level (rssi)
    );

endmodule

// File: rtl/agc_rssi_chk.sv
module agc_rssi_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_tick,
    input logic             gap,
    input logic             preamble_ok,
    input logic             freeze,
    input logic             soft_clr,
    input logic             chan_chg,
    input logic [CNT_W-1:0] rssi
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    a_r1_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !preamble_ok |=> rssi == '0);

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr || chan_chg) |=> rssi == '0);

    a_r5_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gap && preamble_ok && !soft_clr && !chan_chg) |=> $stable(rssi));

    a_r6_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && preamble_ok && !soft_clr && !chan_chg) |=> $stable(rssi));

    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_tick && preamble_ok && !soft_clr && !chan_chg) |=> $stable(rssi));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (preamble_ok && !soft_clr && !chan_chg) |=>
        ({1'b0, rssi} == {1'b0, $past(rssi)} ||
         {1'b0, rssi} == {1'b0, $past(rssi)} + 1'b1 ||
         {1'b0, rssi} + 1'b1 == {1'b0, $past(rssi)}));

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rssi == TOP && preamble_ok && !soft_clr && !chan_chg) |=> rssi != '0);

endmodule

bind agc_rssi_core agc_rssi_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_tick (period_tick),
    .gap         (gap),
    .preamble_ok (preamble_ok),
    .freeze      (freeze),
    .soft_clr    (soft_clr),
    .chan_chg    (chan_chg),
    .rssi        (rssi)
);

// File: tb/tb_agc_rssi_core.sv
`timescale 1ns/1ps
module tb_agc_rssi_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_tick = 1'b0;
    logic [2:0] above_ref = '0;
    logic [2:0] chan_en = '0;
    logic       gap = 1'b0;
    logic       preamble_ok = 1'b0;
    logic       freeze = 1'b0;
    logic       soft_clr = 1'b0;
    logic       chan_chg = 1'b0;
    logic [7:0] rssi;

    always #10 clk = ~clk;

    agc_rssi_core dut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
        .above_ref(above_ref), .chan_en(chan_en), .gap(gap),
        .preamble_ok(preamble_ok), .freeze(freeze),
        .soft_clr(soft_clr), .chan_chg(chan_chg), .rssi(rssi)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model: 0 standby, 1 acquiring, 2 tracking
    int m_phase = 0, m_periods = 0, m_run = 0, m_val = 0;
    bit m_dir = 0;

    task automatic check_now();
        checks++;
        if (int'(rssi) != m_val) begin
            errors++;
            $display("FAIL %s t=%0t rssi actual=%0d expected=%0d", cur_req, $time, rssi, m_val);
        end
    endtask

    function automatic void m_move(bit up);
        if (up && m_val < 255) m_val++;
        else if (!up && m_val > 0) m_val--;
    endfunction

    task automatic cyc(input bit tk, input bit gp, input bit fz, input bit pr,
                       input bit sc, input bit cc, input logic [2:0] ab, input logic [2:0] en);
        bit hot, brk;
        int len;
        @(negedge clk);
        check_now();
        period_tick = tk; gap = gp; freeze = fz; preamble_ok = pr;
        soft_clr = sc; chan_chg = cc; above_ref = ab; chan_en = en;
        hot = (ab & en) != 3'b000;
        brk = sc || cc || !pr;
        if (m_phase == 0) begin
            m_val = 0; m_periods = 0; m_run = 0; m_dir = 0;
            if (!sc && !cc && pr) m_phase = 1;
        end else if (brk) begin
            m_phase = 0; m_val = 0; m_periods = 0; m_run = 0; m_dir = 0;
        end else if (tk && !gp && !fz) begin
            if (m_phase == 1) begin
                m_move(hot);
                m_periods++;
                if (m_periods == 192) m_phase = 2;
                m_run = 0; m_dir = hot;
            end else begin
                len = (hot == m_dir) ? m_run + 1 : 1;
                m_dir = hot;
                if ((hot && len == 2) || (!hot && len == 8)) begin
                    m_move(hot); m_run = 0;
                end else m_run = len;
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        r = 32'h1ACE5;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check_now();                                   // R1 reset value
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1,0,0,0,0,0,3'b111,3'b111); // R1 no preamble
        cur_req = "R2";
        for (int i = 0; i < 20; i++) cyc(1,0,0,1,0,0,3'b001,3'b111);
        for (int i = 0; i < 5; i++)  cyc(1,0,0,1,0,0,3'b000,3'b111);
        cur_req = "R10";
        for (int i = 0; i < 8; i++)  cyc(0,0,0,1,0,0,3'b111,3'b111);
        cur_req = "R5";
        for (int i = 0; i < 8; i++)  cyc(1,1,0,1,0,0,3'b111,3'b111);
        cur_req = "R6";
        for (int i = 0; i < 8; i++)  cyc(1,0,1,1,0,0,3'b111,3'b111);
        cur_req = "R8";
        for (int i = 0; i < 4; i++)  cyc(1,0,0,1,0,0,3'b110,3'b001);
        for (int i = 0; i < 3; i++)  cyc(1,0,0,1,0,0,3'b010,3'b010);
        cur_req = "R9";
        for (int i = 0; i < 30; i++) cyc(1,0,0,1,0,0,3'b000,3'b111);
        cur_req = "R3";
        for (int i = 0; i < 160; i++) cyc(1,0,0,1,0,0,3'b100,3'b100);
        for (int i = 0; i < 40; i++) cyc(1,0,0,1,0,0,3'b000,3'b111);
        cur_req = "R4";
        for (int i = 0; i < 60; i++) cyc(1,0,0,1,0,0,(i % 3 != 2) ? 3'b001 : 3'b000,3'b111);
        for (int i = 0; i < 60; i++) cyc(1,0,0,1,0,0,(i % 8 != 7) ? 3'b000 : 3'b001,3'b111);
        cur_req = "R5";
        for (int i = 0; i < 6; i++) begin
            cyc(1,0,0,1,0,0,3'b001,3'b111);
            cyc(1,1,0,1,0,0,3'b000,3'b111);
        end
        cur_req = "R9";
        for (int i = 0; i < 600; i++) cyc(1,0,0,1,0,0,3'b111,3'b111);
        for (int i = 0; i < 10; i++)  cyc(1,0,0,1,0,0,3'b111,3'b111);
        cur_req = "R7";
        cyc(1,0,0,1,1,0,3'b111,3'b111);
        for (int i = 0; i < 6; i++) cyc(1,0,0,1,0,0,3'b111,3'b111);
        cyc(1,0,0,1,0,1,3'b111,3'b111);
        for (int i = 0; i < 6; i++) cyc(1,0,0,1,0,0,3'b111,3'b111);
        cur_req = "R3";
        for (int i = 0; i < 2500; i++) begin
            r = (r * 1103515245 + 12345) & 32'h7fffffff;
            cyc(r[3] | r[4], r[5] & r[6] & r[7], r[8] & r[9] & r[10],
                !(r[11] & r[12] & r[13] & r[14] & r[15] & r[16] & r[17]),
                r[18] & r[19] & r[20] & r[21] & r[22] & r[23] & r[24],
                r[25] & r[26] & r[27] & r[28] & r[29] & r[30] & r[14],
                r[2:0], (r[21:19] == 3'b000) ? 3'b111 : r[21:19]);
        end
        cur_req = "R1";
        cyc(1,0,0,0,0,0,3'b111,3'b111);
        cyc(1,0,0,0,0,0,3'b111,3'b111);
        @(negedge clk);
        check_now();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule